// File: doc/BRIEF.md
# Periodic SAR ADC Conversion and Serial Readout Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that is started by a rising edge on a convert pin and read back over a three-wire serial link. Each conversion has the same order. The controller briefly pulls the convert line low, then raises it to start the conversion. It holds the line high for the worst-case conversion time and then lowers it, which makes the converter drive its first result bit. The controller waits out the output-enable delay and then clocks the remaining bits with a serial clock. After the last bit it returns the convert line high and presents the 16-bit word on a parallel bus with a one-cycle valid strobe.

A conversion is requested either by a one-cycle `start_i` pulse or continuously while `auto_run_i` is held high. A rate gate makes sure that two conversion starts are never closer together than the minimum cycle time. The conversion wait, the enable delay, the serial half-period and the repeat period are all parameters counted in system clocks. Together with the clock period in nanoseconds, they are checked at elaboration against the converter's minimum timing figures, and against the length of one complete sequence.

The control state machine has six named states. IDLE holds convert high and waits for a request. ARM drives convert low for one cycle. CONVERT holds convert high for the conversion wait. ENABLE holds convert low for the enable delay. SCK_HIGH and SCK_LOW form the two halves of each serial clock period.

The transitions are as follows:
- IDLE to ARM: taken when a request arrives and the rate gate is open.
- ARM to CONVERT: taken after one cycle.
- CONVERT to ENABLE and ENABLE to SCK_HIGH: each taken when its own timer expires.
- SCK_HIGH to SCK_LOW: taken on each falling serial clock edge.
- SCK_LOW back to SCK_HIGH: taken while bits remain.
- SCK_LOW to IDLE: taken after the sixteenth falling edge, and it raises the valid strobe.

Top module: `adc_readout_ctrl`

## Requirements
- R1: During and after a synchronous reset the controller is idle with `cnv_o` high, `sck_o` low and `data_valid_o` low. A conversion interrupted by reset produces no result.
- R2: A conversion starts with a rising edge of `cnv_o`, one cycle after `cnv_o` was pulled low. `cnv_o` then stays high for exactly CONV_CYC clock cycles before it falls.
- R3: The first rising edge of `sck_o` comes exactly EN_CYC cycles after `cnv_o` falls at the end of the conversion. `sdo_i` is sampled for bit 15 on that same clock edge.
- R4: Each readout gives exactly 16 `sck_o` pulses. Each high phase and each low phase between pulses lasts exactly HALF_CYC cycles, and `sck_o` is only ever high while `cnv_o` is low.
- R5: Bits 14 down to 0 are captured from `sdo_i` at the 2nd to the 16th falling edges of `sck_o`, in that order. The result on `data_o` is straight binary with the first received bit in bit 15.
- R6: `data_valid_o` is a single-cycle pulse. It comes HALF_CYC cycles after the 16th falling edge, in the same cycle that `cnv_o` returns high. `data_o` keeps that value until the next pulse.
- R7: Two conversion-start edges of `cnv_o` are never closer than PERIOD_CYC cycles. While `auto_run_i` stays high they are exactly PERIOD_CYC cycles apart.
- R8: A `start_i` pulse is ignored, and not remembered, if it comes during a conversion or while the rate gate is still closed.
- R9: With `start_i` and `auto_run_i` both low, no conversion begins and `cnv_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request for a single conversion |
| auto_run_i | input | 1 | Request conversions back to back at the configured period while high |
| sdo_i | input | 1 | Serial result bit from the converter |
| cnv_o | output | 1 | Convert / output-enable line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | 16 | Last completed result, straight binary |
| data_valid_o | output | 1 | One-cycle strobe marking a new result on `data_o` |

## Verification
The assertions assume the following about the inputs:
- `rst` is asserted at time zero, so the counters in the checker start from known values.
- `start_i` and `auto_run_i` are synchronous to `clk`.
- The only source of `sdo_i` is a converter that updates its bit a short time after each serial clock fall and each convert fall, well inside one clock period.

The stimulus keeps within these assumptions. It changes every request input on the falling clock edge. Its converter model drives `sdo_i` from a known word two nanoseconds after the relevant edge, so the bit held at each sampling edge is always the one the requirements name. The data sweep runs walking-one, walking-zero, all-zero, all-one and arithmetic words through free-running mode. Single-shot, ignored-request and mid-readout reset runs cover the remaining orderings.

// File: rtl/adc_readout_pkg.sv
`timescale 1ns/1ps
package adc_readout_pkg;

    // Sequencer states; order carries no meaning outside the controller.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARM      = 3'd1,
        ST_CONVERT  = 3'd2,
        ST_ENABLE   = 3'd3,
        ST_SCK_HIGH = 3'd4,
        ST_SCK_LOW  = 3'd5
    } ctrl_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
// Down-counting phase timer: load with (length - 1), done while at zero.
module adc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_m1_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_m1_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/adc_rate_gate.sv
`timescale 1ns/1ps
// Opens PERIOD cycles after the last accepted request; open after reset.
module adc_rate_gate #(
    parameter int PERIOD = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    output logic ready_o
);

    localparam int W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] FULL = W'(PERIOD);

    logic [W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= FULL;
        end else if (accept_i) begin
            since_q <= W'(1);
        end else if (since_q != FULL) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign ready_o = (since_q == FULL);

endmodule

// File: rtl/adc_shift_capture.sv
`timescale 1ns/1ps
// Serial capture path: falling-edge counter, MSB-first shift register and
// the result register that is committed once the word is complete.
module adc_shift_capture #(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              fall_i,
    input  logic              commit_i,
    input  logic              sdo_i,
    output logic [CNT_W-1:0]  fall_cnt_o,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_n;
    logic [CNT_W-1:0]  fall_q;
    logic [DATA_W-1:0] data_q;

    // Next shift-register value: every stage takes its lower neighbour,
    // stage 0 takes the serial input.
    for (genvar b = 0; b < DATA_W; b++) begin : g_stage
        if (b == 0) begin : g_lsb
            assign sr_n[b] = sdo_i;
        end else begin : g_upper
            assign sr_n[b] = sr_q[b-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= sr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            fall_q <= '0;
        end else if (fall_i) begin
            fall_q <= fall_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (commit_i) begin
            data_q <= sr_q;
        end
    end

    assign fall_cnt_o = fall_q;
    assign data_o     = data_q;

endmodule

// File: rtl/adc_readout_ctrl.sv
`timescale 1ns/1ps
module adc_readout_ctrl
    import adc_readout_pkg::*;
#(
    parameter int DATA_W            = 16,
    parameter int CLK_NS            = 10,
    parameter int CONV_CYC          = 160,
    parameter int EN_CYC            = 3,
    parameter int HALF_CYC          = 1,
    parameter int PERIOD_CYC        = 200,
    parameter int CONV_MIN_NS       = 1600,
    parameter int EN_MIN_NS         = 25,
    parameter int SCK_HALF_MIN_NS   = 8,
    parameter int SCK_PERIOD_MIN_NS = 18,
    parameter int RATE_MIN_NS       = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              auto_run_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_valid_o
);

    // Cycles from an accepted request until the controller is idle again.
    localparam int SEQ_CYC = 1 + CONV_CYC + EN_CYC + 2 * DATA_W * HALF_CYC;
    localparam int TMR_MAX = max3(CONV_CYC, EN_CYC, HALF_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CNT_W   = $clog2(DATA_W + 1);

    localparam logic [TMR_W-1:0] CONV_M1 = TMR_W'(CONV_CYC - 1);
    localparam logic [TMR_W-1:0] EN_M1   = TMR_W'(EN_CYC - 1);
    localparam logic [TMR_W-1:0] HALF_M1 = TMR_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(DATA_W);

    // ------------------------------------------------------------------
    // Elaboration-time timing checks
    // ------------------------------------------------------------------
    if (CONV_CYC < 1 || CONV_CYC * CLK_NS < CONV_MIN_NS) begin : g_bad_conv
        $error("conversion wait shorter than the worst-case conversion time");
    end
    if (EN_CYC < 1 || EN_CYC * CLK_NS < EN_MIN_NS) begin : g_bad_en
        $error("enable delay shorter than the output-enable time");
    end
    if (HALF_CYC < 1 || HALF_CYC * CLK_NS < SCK_HALF_MIN_NS) begin : g_bad_half
        $error("serial clock half-period too short");
    end
    if (2 * HALF_CYC * CLK_NS < SCK_PERIOD_MIN_NS) begin : g_bad_sck
        $error("serial clock period shorter than the data-valid delay");
    end
    if (PERIOD_CYC * CLK_NS < RATE_MIN_NS) begin : g_bad_rate
        $error("conversion period below the minimum cycle time");
    end
    if (PERIOD_CYC < SEQ_CYC) begin : g_bad_seq
        $error("conversion period cannot hold one full sequence");
    end

    // ------------------------------------------------------------------
    // Internal signals
    // ------------------------------------------------------------------
    ctrl_state_t       state_q;
    ctrl_state_t       state_n;
    logic              advance;
    logic              accept;
    logic              rate_ready;
    logic              tmr_done;
    logic [TMR_W-1:0]  len_m1;
    logic [CNT_W-1:0]  fall_cnt;
    logic              last_fall;
    logic              shift_en;
    logic              fall_en;
    logic              commit_en;
    logic              cnv_q;
    logic              sck_q;
    logic              valid_q;

    assign accept    = (state_q == ST_IDLE) && rate_ready && (start_i || auto_run_i);
    assign last_fall = (fall_cnt == LAST_FALL);

    // Sample points: bit 15 at the end of the enable delay, later bits on
    // every falling serial edge except the first.
    assign shift_en  = ((state_q == ST_ENABLE) && tmr_done) ||
                       ((state_q == ST_SCK_HIGH) && tmr_done && (fall_cnt != '0));
    assign fall_en   = (state_q == ST_SCK_HIGH) && tmr_done;
    assign commit_en = (state_q == ST_SCK_LOW) && tmr_done && last_fall;

    // ------------------------------------------------------------------
    // Sub-blocks
    // ------------------------------------------------------------------
    adc_rate_gate #(
        .PERIOD (PERIOD_CYC)
    ) rate_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .ready_o  (rate_ready)
    );

    adc_phase_timer #(
        .W (TMR_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (advance),
        .len_m1_i (len_m1),
        .done_o   (tmr_done)
    );

    adc_shift_capture #(
        .DATA_W (DATA_W)
    ) capture_i (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (accept),
        .shift_i    (shift_en),
        .fall_i     (fall_en),
        .commit_i   (commit_en),
        .sdo_i      (sdo_i),
        .fall_cnt_o (fall_cnt),
        .data_o     (data_o)
    );

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // ------------------------------------------------------------------
    // Next state
    // ------------------------------------------------------------------
    always_comb begin
        state_n = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_n = ST_ARM;
                    advance = 1'b1;
                end
            end
            ST_ARM: begin
                if (tmr_done) begin
                    state_n = ST_CONVERT;
                    advance = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (tmr_done) begin
                    state_n = ST_ENABLE;
                    advance = 1'b1;
                end
            end
            ST_ENABLE: begin
                if (tmr_done) begin
                    state_n = ST_SCK_HIGH;
                    advance = 1'b1;
                end
            end
            ST_SCK_HIGH: begin
                if (tmr_done) begin
                    state_n = ST_SCK_LOW;
                    advance = 1'b1;
                end
            end
            ST_SCK_LOW: begin
                if (tmr_done) begin
                    state_n = last_fall ? ST_IDLE : ST_SCK_HIGH;
                    advance = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                advance = 1'b1;
            end
        endcase
    end

    // Phase length for the state being entered.
    always_comb begin
        unique case (state_n)
            ST_CONVERT:              len_m1 = CONV_M1;
            ST_ENABLE:               len_m1 = EN_M1;
            ST_SCK_HIGH, ST_SCK_LOW: len_m1 = HALF_M1;
            default:                 len_m1 = '0;
        endcase
    end

    // ------------------------------------------------------------------
    // Outputs, registered from the next state
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_q   <= 1'b1;
            sck_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_q == ST_SCK_LOW) && (state_n == ST_IDLE);
            unique case (state_n)
                ST_IDLE, ST_CONVERT: begin
                    cnv_q <= 1'b1;
                    sck_q <= 1'b0;
                end
                ST_SCK_HIGH: begin
                    cnv_q <= 1'b0;
                    sck_q <= 1'b1;
                end
                default: begin
                    cnv_q <= 1'b0;
                    sck_q <= 1'b0;
                end
            endcase
        end
    end

    assign cnv_o        = cnv_q;
    assign sck_o        = sck_q;
    assign data_valid_o = valid_q;

endmodule

// File: rtl/adc_readout_ctrl_chk.sv
`timescale 1ns/1ps
module adc_readout_ctrl_chk #(
    parameter int DATA_W     = 16,
    parameter int CONV_CYC   = 160,
    parameter int EN_CYC     = 3,
    parameter int HALF_CYC   = 1,
    parameter int PERIOD_CYC = 200
) (
    input logic clk,
    input logic rst,
    input logic cnv,
    input logic sck,
    input logic valid
);

    localparam logic [31:0] SAT = 32'hFFFF_FFFF;

    logic        rst_q = 1'b0;
    logic        cnv_d;
    logic        sck_d;
    logic        in_conv;
    logic [31:0] cnv_hi;
    logic [31:0] sck_hi;
    logic [31:0] sck_lo;
    logic [31:0] since_start;
    logic [31:0] falls;
    logic        start_edge;

    assign start_edge = cnv && !cnv_d && !valid;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_d       <= 1'b1;
            sck_d       <= 1'b0;
            in_conv     <= 1'b0;
            cnv_hi      <= '0;
            sck_hi      <= '0;
            sck_lo      <= '0;
            since_start <= 32'(PERIOD_CYC);
            falls       <= '0;
        end else begin
            cnv_d <= cnv;
            sck_d <= sck;
            cnv_hi <= !cnv ? '0 : (cnv_hi != SAT ? cnv_hi + 1 : cnv_hi);
            sck_hi <= !sck ? '0 : (sck_hi != SAT ? sck_hi + 1 : sck_hi);
            sck_lo <= (sck || cnv) ? '0 : (sck_lo != SAT ? sck_lo + 1 : sck_lo);
            if (start_edge) begin
                since_start <= 32'd1;
            end else if (since_start != SAT) begin
                since_start <= since_start + 1;
            end
            if (start_edge) begin
                in_conv <= 1'b1;
            end else if (!cnv && cnv_d) begin
                in_conv <= 1'b0;
            end
            if (!cnv && cnv_d) begin
                falls <= '0;
            end else if (!sck && sck_d) begin
                falls <= falls + 1;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst_q |-> (cnv && !sck && !valid));

    assert_conv_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cnv && cnv_d && in_conv) |-> (cnv_hi == 32'(CONV_CYC)));

    assert_sck_gated_R4: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cnv);

    assert_sck_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!sck && sck_d) |-> (sck_hi == 32'(HALF_CYC)));

    // R3 covers the first rise after the enable delay, R4 the later ones.
    assert_sck_low_R3: assert property (@(posedge clk) disable iff (rst)
        (sck && !sck_d) |-> (sck_lo == 32'(HALF_CYC) || sck_lo == 32'(EN_CYC)));

    assert_bit_count_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (falls == 32'(DATA_W)));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_valid_cnv_R6: assert property (@(posedge clk) disable iff (rst)
        valid |-> cnv);

    assert_start_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        start_edge |-> (since_start >= 32'(PERIOD_CYC)));

endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .DATA_W     (DATA_W),
    .CONV_CYC   (CONV_CYC),
    .EN_CYC     (EN_CYC),
    .HALF_CYC   (HALF_CYC),
    .PERIOD_CYC (PERIOD_CYC)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .cnv   (cnv_o),
    .sck   (sck_o),
    .valid (data_valid_o)
);

// File: tb/adc_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_readout_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int CONV_CYC   = 160;
    localparam int EN_CYC     = 3;
    localparam int HALF_CYC   = 1;
    localparam int PERIOD_CYC = 200;
    localparam int SWEEP_N    = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              auto_run_i = 1'b0;
    logic              sdo_i;
    logic              cnv_o;
    logic              sck_o;
    logic [DATA_W-1:0] data_o;
    logic              data_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_readout_ctrl #(
        .DATA_W     (DATA_W),
        .CLK_NS     (CLK_PERIOD),
        .CONV_CYC   (CONV_CYC),
        .EN_CYC     (EN_CYC),
        .HALF_CYC   (HALF_CYC),
        .PERIOD_CYC (PERIOD_CYC)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .auto_run_i   (auto_run_i),
        .sdo_i        (sdo_i),
        .cnv_o        (cnv_o),
        .sck_o        (sck_o),
        .data_o       (data_o),
        .data_valid_o (data_valid_o)
    );

    // ------------------------------------------------------------------
    // Result words presented by the converter model, one per rising CNV.
    // ------------------------------------------------------------------
    function automatic logic [15:0] pat(input int n);
        if (n == 0)       return 16'h0000;
        else if (n == 1)  return 16'hFFFF;
        else if (n < 18)  return 16'(1) << (n - 2);
        else if (n < 34)  return ~(16'(1) << (n - 18));
        else              return 16'((n * 40503) ^ (n << 7) ^ 16'h5A3C);
    endfunction

    // Converter model.
    logic [15:0] cur_word = 16'h0;
    int          rise_n   = 0;
    int          bit_idx  = 15;
    logic        m_cnv    = 1'b1;
    logic        m_sck    = 1'b0;

    always @(posedge cnv_o) begin
        cur_word = pat(rise_n);
        rise_n   = rise_n + 1;
    end

    always @(cnv_o or sck_o) begin
        if (!cnv_o && m_cnv) begin
            bit_idx = 15;
        end else if (!sck_o && m_sck && bit_idx > 0) begin
            bit_idx = bit_idx - 1;
        end
        m_cnv = cnv_o;
        m_sck = sck_o;
    end

    assign #2 sdo_i = cur_word[bit_idx[3:0]];

    // ------------------------------------------------------------------
    // Check reporting
    // ------------------------------------------------------------------
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ------------------------------------------------------------------
    // Monitor, sampled on falling clock edges
    // ------------------------------------------------------------------
    int          cyc = 0;
    int          conv_rises = 0;
    int          valids = 0;
    int          last_start = -1;
    bit          last_auto = 1'b0;
    int          t_rise = 0, t_cfall = 0, t_srise = 0, t_sfall = 0;
    int          nfall = 0;
    bit          in_conv = 1'b0;
    bit          first_sck = 1'b0;
    bit          have_data = 1'b0;
    logic [15:0] exp_word = '0;
    logic [15:0] last_data = '0;
    logic        p_cnv = 1'b1, p_sck = 1'b0, p_valid = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            in_conv    = 1'b0;
            first_sck  = 1'b0;
            last_start = -1;
            nfall      = 0;
        end else begin
            if (cnv_o && !p_cnv && !data_valid_o) begin
                conv_rises++;
                if (last_start >= 0) begin
                    check(cyc - last_start >= PERIOD_CYC, "R7 start spacing", cyc - last_start, PERIOD_CYC);
                    if (last_auto && auto_run_i)
                        check(cyc - last_start == PERIOD_CYC, "R7 free-running period", cyc - last_start, PERIOD_CYC);
                end
                if (have_data)
                    check(data_o == last_data, "R6 data held", data_o, last_data);
                last_start = cyc;
                last_auto  = auto_run_i;
                t_rise     = cyc;
                exp_word   = cur_word;
                in_conv    = 1'b1;
                nfall      = 0;
            end
            if (!cnv_o && p_cnv && in_conv) begin
                check(cyc - t_rise == CONV_CYC, "R2 conversion hold", cyc - t_rise, CONV_CYC);
                t_cfall   = cyc;
                first_sck = 1'b1;
            end
            if (sck_o && !p_sck) begin
                check(!cnv_o, "R4 sck gated by cnv", cnv_o, 0);
                if (first_sck)
                    check(cyc - t_cfall == EN_CYC, "R3 enable delay", cyc - t_cfall, EN_CYC);
                else
                    check(cyc - t_sfall == HALF_CYC, "R4 sck low time", cyc - t_sfall, HALF_CYC);
                first_sck = 1'b0;
                t_srise   = cyc;
            end
            if (!sck_o && p_sck) begin
                check(cyc - t_srise == HALF_CYC, "R4 sck high time", cyc - t_srise, HALF_CYC);
                t_sfall = cyc;
                nfall++;
            end
            if (data_valid_o) begin
                valids++;
                check(in_conv, "R1 result only after a full conversion", in_conv, 1);
                check(cnv_o == 1'b1, "R6 cnv high with valid", cnv_o, 1);
                check(nfall == 16, "R4 sck pulse count", nfall, 16);
                check(cyc - t_sfall == HALF_CYC, "R6 valid timing", cyc - t_sfall, HALF_CYC);
                check(data_o == exp_word, "R5 result word", data_o, exp_word);
                last_data = data_o;
                have_data = 1'b1;
                in_conv   = 1'b0;
                if (p_valid)
                    check(1'b0, "R6 valid pulse width", 2, 1);
            end
        end
        p_cnv   = cnv_o;
        p_sck   = sck_o;
        p_valid = data_valid_o;
    end

    // ------------------------------------------------------------------
    // Stimulus
    // ------------------------------------------------------------------
    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valids(input int target, input int limit);
        for (int i = 0; i < limit && valids < target; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        int base_rises;
        int base_valids;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(cnv_o == 1'b1 && sck_o == 1'b0 && data_valid_o == 1'b0,
              "R1 outputs in reset", {cnv_o, sck_o, data_valid_o}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check(cnv_o == 1'b1 && sck_o == 1'b0 && data_valid_o == 1'b0,
              "R1 outputs after reset", {cnv_o, sck_o, data_valid_o}, 3'b100);

        // R9: no request, no conversion
        repeat (300) @(negedge clk);
        check(conv_rises == 0, "R9 no request no conversion", conv_rises, 0);
        check(cnv_o == 1'b1, "R9 cnv idle high", cnv_o, 1);

        // Single shot
        pulse_start();
        wait_valids(1, 400);
        check(valids == 1, "R5 single conversion result", valids, 1);
        check(conv_rises == 1, "R2 single conversion start", conv_rises, 1);

        // R8: requests during a conversion and inside the rate window
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_valids(2, 400);
        pulse_start();
        repeat (300) @(negedge clk);
        check(conv_rises == 2, "R8 busy and early starts ignored", conv_rises, 2);
        check(valids == 2, "R8 result count", valids, 2);

        // Free-running data sweep (R5, R7)
        @(negedge clk);
        auto_run_i = 1'b1;
        wait_valids(2 + SWEEP_N, SWEEP_N * PERIOD_CYC + 1000);
        auto_run_i = 1'b0;
        check(valids == 2 + SWEEP_N, "R7 free-running conversions", valids, 2 + SWEEP_N);
        repeat (400) @(negedge clk);
        check(valids == conv_rises, "R9 stop after auto off", valids, conv_rises);
        base_rises = conv_rises;
        repeat (300) @(negedge clk);
        check(conv_rises == base_rises, "R9 idle after auto off", conv_rises, base_rises);

        // R1: reset in the middle of the serial readout
        base_valids = valids;
        pulse_start();
        repeat (CONV_CYC + EN_CYC + 10) @(negedge clk);
        check(cnv_o == 1'b0, "R1 pre-reset readout active", cnv_o, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(cnv_o == 1'b1 && sck_o == 1'b0 && data_valid_o == 1'b0,
              "R1 mid-readout reset", {cnv_o, sck_o, data_valid_o}, 3'b100);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        check(valids == base_valids, "R1 aborted readout gives no result", valids, base_valids);
        check(cnv_o == 1'b1, "R1 idle after reset", cnv_o, 1);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

endmodule